// File: doc/BRIEF.md
# Reference-Clock Frequency Meter

This block measures the frequency of one of several monitored clocks against its own reference clock. Software programs a window length in monitored-clock periods, picks a monitored channel, opens the free-run gate and sets the detect enable. The block waits for a rising edge of the chosen clock. It then counts reference-clock cycles until the programmed number of further monitored rising edges has arrived. It stores that count in a read-only result register and raises a valid flag.

The result equals the window length times the monitored period, both measured in reference cycles. It therefore falls as the monitored frequency rises: software divides the window length by the result to get the frequency ratio. A typical window is 1024 periods. Software polls the valid flag, reads the result, and then clears the detect enable and the free-run gate. Each monitored input passes through a two-flop synchronizer into the reference domain, and all counting happens there. Each monitored clock must therefore run below half the reference frequency.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, the control word (byte offset 0x00), the monitor word (0x10) and the result word (0x0C) all read zero.
- R2: The control word holds the window length in bits 23:0, the detect enable in bit 24 and the channel select in bits 27:26. Bits 25 and 31:28 read zero, so writing all ones reads back 0x0DFFFFFF.
- R3: The monitor word holds the free-run enable in bit 8, which software can read and write, and the valid flag in bit 0, which writes do not change. All its other bits read zero. Offsets other than 0x00, 0x0C and 0x10 read zero and ignore writes.
- R4: With the free-run enable set, a measurement stores N×P in the result word. N is the window length and P is the monitored period in reference cycles. The count runs from the first monitored rising edge seen after the detect enable is set to the Nth rising edge after it.
- R5: A window length of zero is measured as a window of one period (result P).
- R6: While the free-run enable is low, monitored edges are ignored, no window completes and valid stays 0. Setting the free-run enable later lets the pending measurement complete with the correct result.
- R7: Clearing the detect enable clears valid by the next cycle and leaves the result word unchanged. Setting the detect enable again starts a fresh measurement.
- R8: Channel select values 0 to 3 choose which monitored input is measured.
- R9: With the free-run enable set, valid rises no more than (N+1)×P+8 reference cycles after the write that sets the detect enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from busAddr |
| monClk | input | 4 | Monitored clock inputs, one per channel |

## Verification
A corrupted window or reference counter appears at the ports as a result word that differs from the arithmetic N×P. That value can be read as soon as valid rises, roughly (N+1)×P cycles after detection starts. A stuck control state shows up as valid failing to rise within the R9 bound, or as valid staying high one cycle after the detect enable is cleared. The bench sweeps every channel, each with a different period, across several window lengths including zero and 1024. It covers all the gating and restart orderings.

// File: rtl/fmeter_pkg.sv
`timescale 1ns/1ps
package fmeter_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_VALUE = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MON   = 8'h10;

  // control-word field positions (decoded by software)
  localparam int unsigned CTRL_DET_BIT = 24;
  localparam int unsigned CTRL_SEL_LO  = 26;
  localparam int unsigned MON_VALID_BIT = 0;
  localparam int unsigned MON_FREE_BIT  = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } meterState_t;

  typedef struct packed {
    logic clear;    // hold counters at zero
    logic start;    // first monitored edge seen: open window
    logic run;      // window open: count reference cycles
    logic capture;  // window closed: latch result
  } meterStrobe_t;
endpackage

// File: rtl/fmeter_dp.sv
`timescale 1ns/1ps
module fmeter_dp
  import fmeter_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned VAL_W  = 32,
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] monClk,
  input  logic [SEL_W-1:0]  chSel,
  input  logic              freeRunEn,
  input  logic [CNT_W-1:0]  windowLen,
  input  meterStrobe_t      stb,
  output logic              edgePulse,
  output logic              windowEnd,
  output logic [VAL_W-1:0]  resultVal
);
  localparam logic [VAL_W-1:0] REF_MAX = '1;

  logic [NUM_CH-1:0] syncA;
  logic [NUM_CH-1:0] syncB;

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA[ch] <= 1'b0;
          syncB[ch] <= 1'b0;
        end else begin
          syncA[ch] <= monClk[ch];
          syncB[ch] <= syncA[ch];
        end
      end
    end
  endgenerate

  logic selLevel;
  logic selPrev;
  assign selLevel = syncB[chSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selPrev <= 1'b0;
    else       selPrev <= selLevel;
  end

  assign edgePulse = freeRunEn & selLevel & ~selPrev;

  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] tgtLatch;
  logic [VAL_W-1:0] refCnt;
  logic [CNT_W:0]   edgeNext;

  assign edgeNext  = {1'b0, edgeCnt} + 1'b1;
  assign windowEnd = edgePulse && (edgeNext == {1'b0, tgtLatch});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt  <= '0;
      tgtLatch <= '0;
      refCnt   <= '0;
    end else if (stb.clear) begin
      edgeCnt <= '0;
      refCnt  <= '0;
    end else if (stb.start) begin
      edgeCnt  <= '0;
      refCnt   <= {{(VAL_W-1){1'b0}}, 1'b1};
      tgtLatch <= windowLen;
    end else if (stb.run) begin
      if (refCnt != REF_MAX) refCnt <= refCnt + 1'b1;
      if (edgePulse) edgeCnt <= edgeNext[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            resultVal <= '0;
    else if (stb.capture) resultVal <= refCnt;
  end

  // R5: an open window never holds more edges than its latched length
  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.run |-> (edgeCnt < tgtLatch));
endmodule

// File: rtl/fmeter_ctrl.sv
`timescale 1ns/1ps
module fmeter_ctrl
  import fmeter_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned VAL_W  = 32,
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              edgePulse,
  input  logic              windowEnd,
  input  logic [VAL_W-1:0]  resultVal,
  output logic [SEL_W-1:0]  chSel,
  output logic              freeRunEn,
  output logic [CNT_W-1:0]  windowLen,
  output meterStrobe_t      stb
);
  logic [CNT_W-1:0] cycleCnt;
  logic             detEn;
  meterState_t      state;
  logic             valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt  <= '0;
      detEn     <= 1'b0;
      chSel     <= '0;
      freeRunEn <= 1'b0;
    end else if (busWe) begin
      if (busAddr == OFF_CTRL) begin
        cycleCnt <= busWdata[CNT_W-1:0];
        detEn    <= busWdata[CTRL_DET_BIT];
        chSel    <= busWdata[CTRL_SEL_LO +: SEL_W];
      end else if (busAddr == OFF_MON) begin
        freeRunEn <= busWdata[MON_FREE_BIT];
      end
    end
  end

  assign windowLen = (cycleCnt == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : cycleCnt;

  always_comb begin
    stb         = '0;
    stb.clear   = (state == ST_IDLE) || !detEn;
    stb.start   = (state == ST_ARM) && detEn && edgePulse;
    stb.run     = (state == ST_RUN) && detEn;
    stb.capture = stb.run && windowEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else if (!detEn) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE: state <= ST_ARM;
        ST_ARM:  if (stb.start)   state <= ST_RUN;
        ST_RUN:  if (stb.capture) state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

  assign valid = (state == ST_DONE);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_CTRL: begin
        busRdata[CNT_W-1:0]              = cycleCnt;
        busRdata[CTRL_DET_BIT]           = detEn;
        busRdata[CTRL_SEL_LO +: SEL_W]   = chSel;
      end
      OFF_VALUE: busRdata[VAL_W-1:0] = resultVal;
      OFF_MON: begin
        busRdata[MON_VALID_BIT] = valid;
        busRdata[MON_FREE_BIT]  = freeRunEn;
      end
      default: busRdata = '0;
    endcase
  end

  // R7: a cleared detect enable drops valid on the next cycle
  p_clear_drops_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !detEn |=> !valid);
  // R7: valid only rises out of a measurement that was enabled
  p_valid_from_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(valid) |-> $past(detEn));
  // R6: a gated monitored clock freezes a pending measurement
  p_gated_arm_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM && detEn && !freeRunEn) |=> (state == ST_ARM));
  p_gated_run_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && detEn && !freeRunEn) |=> (state == ST_RUN));
endmodule

// File: rtl/clk_freq_meter.sv
`timescale 1ns/1ps
module clk_freq_meter
  import fmeter_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned VAL_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic [NUM_CH-1:0] monClk
);
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  meterStrobe_t     stb;
  logic             edgePulse;
  logic             windowEnd;
  logic [VAL_W-1:0] resultVal;
  logic [SEL_W-1:0] chSel;
  logic             freeRunEn;
  logic [CNT_W-1:0] windowLen;

  fmeter_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .VAL_W(VAL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .edgePulse(edgePulse),
    .windowEnd(windowEnd), .resultVal(resultVal), .chSel(chSel),
    .freeRunEn(freeRunEn), .windowLen(windowLen), .stb(stb)
  );

  fmeter_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .VAL_W(VAL_W)) u_dp (
    .clk(clk), .rstN(rstN), .monClk(monClk), .chSel(chSel),
    .freeRunEn(freeRunEn), .windowLen(windowLen), .stb(stb),
    .edgePulse(edgePulse), .windowEnd(windowEnd), .resultVal(resultVal)
  );

  // R4: every completed window reports at least one reference cycle
  p_result_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRdata[MON_VALID_BIT] && busAddr == OFF_MON) |-> (resultVal != '0));
endmodule

// File: tb/sim_clk_freq_meter.sv
`timescale 1ns/1ps
module sim_clk_freq_meter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  monClk = '0;

  int errors = 0;
  int checks = 0;
  int halfP [4] = '{1, 2, 3, 5};
  int phase [4] = '{0, 0, 0, 0};

  always #5 clk = ~clk;

  clk_freq_meter u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .monClk(monClk)
  );

  // monitored clocks: exact integer multiples of the reference period
  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (phase[c] + 1 >= halfP[c]) begin
        phase[c]  <= 0;
        monClk[c] <= ~monClk[c];
      end else begin
        phase[c] <= phase[c] + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  // polls valid; returns number of polls taken (or -1 on timeout)
  task automatic waitValid(input int limit, output int polls);
    logic [31:0] m;
    polls = -1;
    for (int i = 1; i <= limit; i++) begin
      rd(8'h10, m);
      if (m[0]) begin
        polls = i;
        break;
      end
    end
  endtask

  task automatic measure(input int sel, input int n, input string req);
    logic [31:0] v;
    int polls;
    int neff;
    int per;
    int bound;
    neff  = (n == 0) ? 1 : n;
    per   = 2 * halfP[sel];
    bound = (neff + 1) * per + 8;
    wr(8'h10, 32'h100);
    wr(8'h00, (32'(sel) << 26) | 32'(n));
    wr(8'h00, (32'(sel) << 26) | (32'h1 << 24) | 32'(n));
    waitValid(bound + 20, polls);
    checks++;
    if (polls < 0 || polls > bound) begin
      errors++;
      $display("FAIL R9: actual polls=%0d expected <=%0d (ch%0d n=%0d)", polls, bound, sel, n);
    end
    rd(8'h0C, v);
    check(req, v, 32'(neff * per));
    wr(8'h00, (32'(sel) << 26) | 32'(n));
    rd(8'h10, v);
    check("R7 valid cleared", v, 32'h100);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int polls;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h10, v); check("R1 mon", v, 32'h0);
    rd(8'h0C, v); check("R1 value", v, 32'h0);

    // R2 field layout (free-run low, so nothing completes)
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 ctrl readback", v, 32'h0DFF_FFFF);
    wr(8'h00, 32'h0);
    rd(8'h00, v); check("R2 ctrl clear", v, 32'h0);

    // R3 monitor word: only bit 8 writable; unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R3 mon readback", v, 32'h100);
    wr(8'h10, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R3 unmapped read", v, 32'h0);
    rd(8'h00, v); check("R3 unmapped write ignored", v, 32'h0);
    wr(8'h0C, 32'h1234_5678);
    rd(8'h0C, v); check("R3 value read-only", v, 32'h0);

    // R4 / R5 / R8 sweep: every channel, several window lengths
    for (int s = 0; s < 4; s++) begin
      foreach (halfP[k]) begin end
      measure(s, 0, "R5 zero window");
      measure(s, 1, "R4 R8 n=1");
      measure(s, 2, "R4 R8 n=2");
      measure(s, 5, "R4 R8 n=5");
      measure(s, 16, "R4 R8 n=16");
    end
    measure(1, 1024, "R4 n=1024");

    // R6 gated monitored clock
    wr(8'h10, 32'h0);
    wr(8'h00, (32'd2 << 26) | (32'h1 << 24) | 32'd3);
    repeat (200) @(negedge clk);
    rd(8'h10, v); check("R6 gated no valid", v, 32'h0);
    rd(8'h0C, v); check("R6 result unchanged", v, 32'd1024 * 4);
    wr(8'h10, 32'h100);
    waitValid(100, polls);
    rd(8'h10, v); check("R6 ungated valid", v, 32'h101);
    rd(8'h0C, v); check("R6 ungated result", v, 32'd18);

    // R7 clear keeps result; re-enable measures fresh
    wr(8'h00, (32'd2 << 26) | 32'd3);
    rd(8'h10, v); check("R7 valid low after clear", v, 32'h100);
    rd(8'h0C, v); check("R7 result kept", v, 32'd18);
    wr(8'h00, (32'd3 << 26) | (32'h1 << 24) | 32'd4);
    rd(8'h10, v); check("R7 fresh start not valid", v, 32'h100);
    waitValid(100, polls);
    rd(8'h0C, v); check("R7 fresh result", v, 32'd40);
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule